// File: doc/BRIEF.md
# Period-match timer with prescaler and postscaler

This block is an 8-bit up-counter whose cycle length is set by a programmable period register rather than by overflow. The counter starts at zero and steps up by one on every prescaled clock enable. On the step after it equals the period value it returns to zero, and it emits a one-cycle match pulse. The prescaler divides the system clock by 1, 4 or 16. Every match pulse is also fed to a postscaler that counts 1 to 16 matches before it sets a sticky interrupt flag.

The raw match pulse is a port of its own, so a PWM duty stage or a serial bit clock can use it as a time base. Software writes a control word (run, postscale, prescale), the period register and the counter. Any write to the counter or to the control word restarts the prescaler and the postscaler from zero.

Top module: `period_timer`

## Requirements
- R1: After reset, count is 0, match and flag are 0, the timer is stopped, and the period register holds 0xFF.
- R2: A control write latches ctrl_din with bit 6 = run, bits 5:2 = postscale field and bits 1:0 = prescale field. The new value governs counting from the next clock on.
- R3: While running, count steps from 0 up to the period value P. On the following step it becomes 0, so one period lasts (P+1) × prescale ratio clocks.
- R4: Prescale field 0 gives a step every clock, field 1 every 4 clocks, and fields 2 and 3 every 16 clocks.
- R5: The match output is high for exactly the one cycle in which count has just returned from P to 0.
- R6: With postscale field n, the flag is set together with every (n+1)-th match pulse, counting from the last counter or control write.
- R7: The flag stays set until a flag_clr pulse clears it.
- R8: With run cleared, count holds its value and no match occurs. Setting run again resumes counting from the held value.
- R9: A counter or control write clears the prescaler and postscaler progress. No count step and no match happen in the cycle of that write.
- R10: A count loaded above P counts up to 0xFF and then wraps to 0 without a match pulse. Normal periods follow from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_din | input | 7 | Control word: run, postscale field, prescale field |
| period_wr | input | 1 | Period register write strobe |
| period_din | input | 8 | New period value |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_din | input | 8 | New counter value |
| flag_clr | input | 1 | Clears the interrupt flag |
| count | output | 8 | Current counter value |
| match | output | 1 | One-cycle pulse at each period match |
| flag | output | 1 | Sticky interrupt flag from the postscaler |

## Verification
The assertions assume that counter and control writes are single-cycle strobes driven between clock edges. They also assume that flag_clr is never raised in the cycle where a postscaler event sets the flag, and the stimulus keeps to that. Flag clears are issued only while the timer is stopped, which guarantees no event can coincide with them. Every period, counter and control update in the stimulus is a one-clock pulse that follows a stop or comes during steady running. This keeps each step of the expected timeline computable from the write edge.

// File: rtl/tm_pkg.sv
package tm_pkg;
  localparam int PRE_SEL_W = 2;
  localparam int POST_W    = 4;
  localparam int PRE_CNT_W = 4;

  typedef struct packed {
    logic                 run;
    logic [POST_W-1:0]    post;
    logic [PRE_SEL_W-1:0] pre;
  } tm_ctrl_t;

  // last prescaler state before an enable: ratio minus one
  function automatic logic [PRE_CNT_W-1:0] pre_last(input logic [PRE_SEL_W-1:0] sel);
    case (sel)
      2'd0:    pre_last = 4'd0;
      2'd1:    pre_last = 4'd3;
      default: pre_last = 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/tm_prescale.sv
module tm_prescale
  import tm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 clr,
  input  logic [PRE_SEL_W-1:0] sel,
  output logic                 tick
);
  logic [PRE_CNT_W-1:0] pc_q, pc_d;

  always_comb begin
    tick = run && !clr && (pc_q == pre_last(sel));
    pc_d = pc_q;
    if (clr)       pc_d = '0;
    else if (tick) pc_d = '0;
    else if (run)  pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/tm_counter.sv
module tm_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          per_wr,
  input  logic [CW-1:0] per_val,
  output logic [CW-1:0] count,
  output logic [CW-1:0] period,
  output logic          hit,
  output logic          match
);
  logic [CW-1:0] cnt_q, cnt_d, per_q, per_d;
  logic          match_q;

  always_comb begin
    hit   = tick && (cnt_q == per_q);
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (hit)  cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    per_d = per_wr ? per_val : per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= '1;
      match_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      match_q <= hit;
    end
  end

  assign count  = cnt_q;
  assign period = per_q;
  assign match  = match_q;
endmodule

// File: rtl/tm_postscale.sv
module tm_postscale
  import tm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ev,
  input  logic [POST_W-1:0] sel,
  output logic              fire
);
  logic [POST_W-1:0] ec_q, ec_d;

  always_comb begin
    fire = ev && (ec_q == sel);
    ec_d = ec_q;
    if (clr)       ec_d = '0;
    else if (fire) ec_d = '0;
    else if (ev)   ec_d = ec_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ec_q <= '0;
    else        ec_q <= ec_d;
  end
endmodule

// File: rtl/period_timer.sv
module period_timer
  import tm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctrl_wr,
  input  logic [$bits(tm_ctrl_t)-1:0] ctrl_din,
  input  logic                      period_wr,
  input  logic [CW-1:0]             period_din,
  input  logic                      cnt_wr,
  input  logic [CW-1:0]             cnt_din,
  input  logic                      flag_clr,
  output logic [CW-1:0]             count,
  output logic                      match,
  output logic                      flag
);
  logic     rst_meta, rst_sync_n;
  tm_ctrl_t ctrl_q, ctrl_d;
  logic     flag_q, flag_d;
  logic     wr_any, tick, hit, fire, run_en;
  logic [CW-1:0] per_val;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign wr_any = ctrl_wr || cnt_wr;
  assign run_en = ctrl_q.run;

  always_comb begin
    ctrl_d = ctrl_wr ? tm_ctrl_t'(ctrl_din) : ctrl_q;
    flag_d = fire || (flag_q && !flag_clr);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  tm_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run_en),
    .clr   (wr_any),
    .sel   (ctrl_q.pre),
    .tick  (tick)
  );

  tm_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .load     (cnt_wr),
    .load_val (cnt_din),
    .per_wr   (period_wr),
    .per_val  (period_din),
    .count    (count),
    .period   (per_val),
    .hit      (hit),
    .match    (match)
  );

  tm_postscale u_post (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (wr_any),
    .ev    (hit),
    .sel   (ctrl_q.post),
    .fire  (fire)
  );

  assign flag = flag_q;
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic [CW-1:0] period,
  input logic          match,
  input logic          flag,
  input logic          run,
  input logic          cnt_wr,
  input logic          ctrl_wr,
  input logic          flag_clr
);
  a_r5_match_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (count == '0));

  a_r3_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_wr) && (count != $past(count))) |->
      ((count == CW'($past(count) + 1)) || (count == '0)));

  a_r10_no_match_above: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_wr) && ($past(count) > $past(period))) |-> !match);

  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run) && !$past(cnt_wr)) |-> ($stable(count) && !match));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag) && !$past(flag_clr)) |-> flag);

  a_r6_flag_with_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> match);

  a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_wr || ctrl_wr) |-> !match);
endmodule

bind period_timer tm_checker #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .count    (count),
  .period   (per_val),
  .match    (match),
  .flag     (flag),
  .run      (run_en),
  .cnt_wr   (cnt_wr),
  .ctrl_wr  (ctrl_wr),
  .flag_clr (flag_clr)
);

// File: tb/sim_period_timer.sv
`timescale 1ns/1ps
module sim_period_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_wr, period_wr, cnt_wr, flag_clr;
  logic [6:0] ctrl_din;
  logic [7:0] period_din, cnt_din;
  logic [7:0] count;
  logic       match, flag;

  typedef struct {
    int    cnt;
    bit    m;
    bit    f;
    string tag;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    fails = 0;
  bit    exp_flag = 0;
  int    cur_cnt = 0;

  always #2 clk = ~clk;

  period_timer u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_din(ctrl_din),
    .period_wr(period_wr), .period_din(period_din), .cnt_wr(cnt_wr),
    .cnt_din(cnt_din), .flag_clr(flag_clr), .count(count), .match(match),
    .flag(flag)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // monitor: compare each expected item away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(count == it.cnt[7:0], it.tag, "count", count, it.cnt);
      check(match == it.m, it.tag, "match", match, it.m);
      check(flag == it.f, it.tag, "flag", flag, it.f);
    end
  end

  task automatic push(input int c, input bit m, input bit f, input string tag);
    item_t it;
    it.cnt = c; it.m = m; it.f = f; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic next_cycle();
    @(posedge clk); #1;
  endtask

  // stop, load period and counter, clear flag (R2, R7)
  task automatic setup(input int p, input int c0);
    ctrl_din = 7'd0; ctrl_wr = 1;
    period_din = p[7:0]; period_wr = 1;
    cnt_din = c0[7:0]; cnt_wr = 1;
    flag_clr = 1;
    next_cycle();
    ctrl_wr = 0; period_wr = 0; cnt_wr = 0; flag_clr = 0;
    exp_flag = 0; cur_cnt = c0;
    push(c0, 0, 0, "R7");
  endtask

  // stop and observe the held state (R8)
  task automatic hold(input int n, input string tag);
    ctrl_din = 7'd0; ctrl_wr = 1;
    next_cycle();
    ctrl_wr = 0;
    for (int k = 0; k < n; k++) begin
      push(cur_cnt, 0, exp_flag, tag);
      if (k < n - 1) next_cycle();
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1;
    next_cycle();
    flag_clr = 0;
    exp_flag = 0;
    push(cur_cnt, 0, 0, "R7");
  endtask

  // start a run by control write or counter write; expectations in closed form
  task automatic phase(input bit via_cnt, input int c0, input int p, input int sel,
                       input int n, input int len, input string tag);
    int r, d;
    r = (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
    d = (c0 <= p) ? (p + 1 - c0) : (256 - c0);
    if (via_cnt) begin
      cnt_din = c0[7:0]; cnt_wr = 1;
    end else begin
      ctrl_din = {1'b1, n[3:0], sel[1:0]}; ctrl_wr = 1;
    end
    next_cycle();
    cnt_wr = 0; ctrl_wr = 0;
    for (int k = 0; k < len; k++) begin
      int t, c, mcount;
      bit tick_now, m, fire;
      t = k / r;
      tick_now = (k > 0) && (k % r == 0);
      c = (t < d) ? (c0 + t) : ((t - d) % (p + 1));
      m = tick_now && (t >= d) && ((t - d) % (p + 1) == 0) && ((c0 <= p) || (t > d));
      if (c0 <= p) mcount = (t >= d) ? ((t - d) / (p + 1) + 1) : 0;
      else         mcount = (t > d) ? ((t - d) / (p + 1)) : 0;
      fire = m && (mcount % (n + 1) == 0);
      if (fire) exp_flag = 1;
      cur_cnt = c;
      push(c, m, exp_flag, tag);
      if (k < len - 1) next_cycle();
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++; total++;
    $display("FAIL all: watchdog expired, actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 0;
    ctrl_wr = 0; period_wr = 0; cnt_wr = 0; flag_clr = 0;
    ctrl_din = '0; period_din = '0; cnt_din = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) next_cycle();
    push(0, 0, 0, "R1");                       // reset state
    next_cycle();
    phase(0, 0, 255, 0, 0, 262, "R1");         // default period 0xFF
    setup(5, 0);  phase(0, 0, 5, 0, 0, 20, "R3");
    setup(3, 0);  phase(0, 0, 3, 1, 2, 60, "R4");
    setup(2, 0);  phase(0, 0, 2, 2, 1, 110, "R4");
    setup(1, 0);  phase(0, 0, 1, 3, 0, 70, "R4");   // fourth encoding acts as 16
    setup(0, 0);  phase(0, 0, 0, 0, 15, 40, "R6");  // flag every 16th match
    setup(4, 0);  phase(0, 0, 4, 1, 0, 10, "R8");
    hold(8, "R8");
    phase(0, cur_cnt, 4, 1, 0, 30, "R8");           // resume from held value, R2
    hold(4, "R7");                                  // flag stays set
    clear_flag();
    phase(0, cur_cnt, 4, 1, 0, 30, "R9");
    phase(1, 1, 4, 1, 0, 30, "R9");                 // counter write mid-prescale
    setup(1, 0);  phase(0, 0, 1, 0, 1, 3, "R9");
    phase(0, cur_cnt, 1, 0, 1, 6, "R9");            // control write restarts postscaler
    setup(16, 254); phase(0, 254, 16, 0, 0, 40, "R10");
    next_cycle();
    next_cycle();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule